// File: doc/BRIEF.md
# SPI Byte Master Shift Engine

This block is an 8-bit SPI master. It sits behind one data port that the host can both write and read. When the block is idle, a host write loads the transmit byte and starts one transfer at once. The engine then asserts slave select and produces sixteen serial-clock edges at a rate set by a programmable divider. It drives MOSI on one edge of each bit and samples MISO on the opposite edge. Reads return a separate receive buffer. That buffer changes only when a byte has been fully received, never while bits are still shifting.

The clock polarity (`cpol`) and clock phase (`cpha`) inputs select any of the four SPI clock modes. The `lsb_first` input selects the bit order. The same order applies to the byte sent and to the byte received. The host watches `busy` and waits for the one-cycle `done` pulse before it reads the result.

Top module: `spi_byte_master`

## Requirements
- R1: While reset is held and right after it is released, `ss_n`=1, `busy`=0, `done`=0 and `sclk` equals `cpol`.
- R2: A write while idle makes `busy`=1 and `ss_n`=0 from the following cycle. Each transfer then produces exactly 16 `sclk` edges, 8 leading and 8 trailing.
- R3: Whenever no transfer is active, `sclk` rests at the level of `cpol`.
- R4: The mode is selected as follows. With `cpha`=0, MISO is sampled on each leading edge and MOSI changes on trailing edges. With `cpha`=1, MOSI changes on leading edges and MISO is sampled on trailing edges. A leading edge takes `sclk` away from `cpol`. MOSI never changes on a sampling edge.
- R5: With `cpha`=0, the first data bit is already on MOSI in the first cycle that `ss_n` is low, before any `sclk` edge.
- R6: With `lsb_first`=0, bit 7 goes out first and the first bit received becomes bit 7. With `lsb_first`=1, bit 0 goes out first and the first bit received becomes bit 0.
- R7: `done` is high for exactly one cycle. If the write is sampled at clock edge c0 and H = `div`+1, then `done` is high in the cycle after edge c0+16H+1. In that same cycle `busy` is 0, `ss_n` is 1, and `rd_data` already holds the newly received byte.
- R8: `rd_data` keeps the previously received byte for the whole of a transfer, until the cycle in which `done` rises.
- R9: A write while `busy` is 1 has no effect. The byte in progress goes out unchanged and its timing is not disturbed.
- R10: Consecutive `sclk` edges are exactly `div`+1 clock cycles apart. The first edge comes `div`+1 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: bit 0 shifted first; 0: bit 7 shifted first |
| div | input | DIV_W | Half-period of sclk minus one, in clock cycles |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Receive buffer: last complete byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions take for granted that `cpol`, `cpha`, `lsb_first` and `div` do not change while `busy` is high. The properties on sclk quietness, MOSI stability and divider range depend on this. They also assume that MISO is stable at the system-clock edges on which the engine samples it. The stimulus changes the mode inputs only between transfers, while idle. It moves MISO only on the falling system-clock edge after a slave-side sclk edge, so each bit is stable for at least half a system cycle before it is sampled. Writes during a transfer are issued on purpose to exercise R9.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/spi_clk_gen.sv
`timescale 1ns/1ps
module spi_clk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] hc_q, hc_d;

  always_comb begin
    hc_d = hc_q;
    if (!run)            hc_d = '0;
    else if (hc_q == div) hc_d = '0;
    else                 hc_d = hc_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

  assign tick = run && (hc_q == div);

  // R10
  hc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc_q <= div));
endmodule

// File: rtl/spi_shift.sv
`timescale 1ns/1ps
module spi_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         shift_out,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)
      tx_d = load_data;
    else if (shift_out)
      tx_d = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (sample)
      rx_d = lsb_first ? {miso, rx_q[W-1:1]} : {rx_q[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = lsb_first ? tx_q[0] : tx_q[W-1];
  assign rx_word = rx_q;

  // R4
  opposite_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> !(shift_out || load));
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  output logic              busy,
  output logic              done
);
  import spi_pkg::*;

  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  xfer_state_t       state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              tog_q, tog_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              run, tick, start, is_sample, is_setup;
  logic [DATA_W-1:0] rx_word;

  assign run   = (state_q == ST_RUN);
  assign start = wr_en && (state_q == ST_IDLE);

  spi_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .div   (div),
    .tick  (tick)
  );

  // even edge index = leading edge, odd = trailing
  assign is_sample = tick && (edge_q[0] == cpha);
  assign is_setup  = tick && (edge_q[0] != cpha) &&
                     (cpha ? (edge_q != '0) : (edge_q != LAST_EDGE));

  spi_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (start),
    .load_data (wr_data),
    .lsb_first (lsb_first),
    .shift_out (is_setup),
    .sample    (is_sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    tog_d   = tog_q;
    done_d  = 1'b0;
    rxbuf_d = rxbuf_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          edge_d  = '0;
          tog_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          tog_d  = ~tog_q;
          edge_d = edge_q + EDGE_W'(1);
          if (edge_q == LAST_EDGE) state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        rxbuf_d = rx_word;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      tog_q   <= 1'b0;
      done_q  <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      tog_q   <= tog_d;
      done_q  <= done_d;
      rxbuf_q <= rxbuf_d;
    end
  end

  assign sclk    = cpol ^ tog_q;
  assign ss_n    = (state_q == ST_IDLE);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rxbuf_q;

  // R3
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (sclk == cpol));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!busy && ss_n));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !tick) |=> $stable(mosi));

  // R8
  rxbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    run |=> $stable(rd_data));

  // R2
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && !tick) |=> $stable(sclk));
endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic       clk, rst_n;
  logic       cpol, cpha, lsb_first;
  logic [7:0] div;
  logic       wr_en;
  logic [7:0] wr_data, rd_data;
  logic       sclk, mosi, miso, ss_n, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .div(div), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitpos(input bit lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  // {cpol, cpha, lsb_first, div[7:0], tx[7:0], slave byte[7:0]}
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'd1, 8'h96, 8'hC3},
    {1'b1, 1'b0, 1'b0, 8'd2, 8'h5A, 8'h81},
    {1'b1, 1'b1, 1'b0, 8'd0, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 1'b1, 8'd3, 8'h01, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'd0, 8'hB2, 8'h4D},
    {1'b1, 1'b0, 1'b1, 8'd1, 8'h7E, 8'hE7},
    {1'b1, 1'b1, 1'b1, 8'd2, 8'h13, 8'hC8}
  };

  task automatic xfer(input bit pol, input bit pha, input bit lsb, input logic [7:0] dv,
                      input logic [7:0] tx, input logic [7:0] sl, input bit mid_write);
    int h, edges, sk, rk, done_t, done_cnt, spacing_bad;
    logic [7:0] rcv, prev_rx;
    logic prev_sclk;
    bit leading;
    h = int'(dv) + 1;
    edges = 0; sk = 0; rk = 0; done_t = -1; done_cnt = 0; spacing_bad = 0;
    rcv = '0;
    @(negedge clk);
    cpol = pol; cpha = pha; lsb_first = lsb; div = dv;
    @(negedge clk);
    chk(sclk == pol && !busy, "R3 idle sclk", sclk, pol);
    prev_rx = rd_data;
    wr_en = 1'b1; wr_data = tx;
    for (int t = 0; t <= 16 * h + 4; t++) begin
      @(negedge clk);
      wr_en = mid_write && (t == 2);
      wr_data = mid_write ? ~tx : tx;
      if (t == 0) begin
        chk(!ss_n && busy, "R2 start", {ss_n, busy}, 2'b01);
        if (!pha) chk(mosi == tx[bitpos(lsb, 0)], "R5 first bit", mosi, tx[bitpos(lsb, 0)]);
        miso = sl[bitpos(lsb, 0)];
        if (!pha) sk = 1;
        prev_sclk = sclk;
      end else begin
        if (sclk != prev_sclk) begin
          leading = (sclk != pol);
          if (t != (edges + 1) * h) spacing_bad++;
          edges++;
          if (leading == !pha) begin
            if (rk < 8) rcv[bitpos(lsb, rk)] = mosi;
            rk++;
          end else begin
            if (sk < 8) miso = sl[bitpos(lsb, sk)];
            sk++;
          end
          prev_sclk = sclk;
        end
        if (t == h + 1 && busy)
          chk(rd_data == prev_rx, "R8 rx buffer hold", rd_data, prev_rx);
      end
      if (done) begin
        done_cnt++;
        if (done_t < 0) begin
          done_t = t;
          chk(!busy && ss_n, "R7 idle at done", {busy, ss_n}, 2'b01);
          chk(rd_data == sl, "R6 R7 received byte", rd_data, sl);
        end
      end
    end
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(spacing_bad == 0, "R10 edge spacing", spacing_bad, 0);
    chk(rcv == tx, mid_write ? "R9 busy write ignored" : "R4 R6 sent byte", rcv, tx);
    chk(done_t == 16 * h + 1 && done_cnt == 1, "R7 done timing", done_t, 16 * h + 1);
    chk(sclk == pol, "R3 sclk after transfer", sclk, pol);
  endtask

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; div = 8'd0;
    wr_en = 1'b0; wr_data = 8'h00; miso = 1'b0;
    repeat (3) @(negedge clk);
    chk(ss_n && !busy && !done && sclk == 1'b0, "R1 reset state",
        {ss_n, busy, done, sclk}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ss_n && !busy && !done && sclk == 1'b0, "R1 after release",
        {ss_n, busy, done, sclk}, 4'b1000);

    foreach (VEC[i])
      xfer(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R9: write while busy, both phases
    xfer(1'b0, 1'b0, 1'b0, 8'd2, 8'hC6, 8'h5E, 1'b1);
    xfer(1'b1, 1'b1, 1'b1, 8'd1, 8'h29, 8'hA1, 1'b1);

    // R3: idle level follows cpol with no transfer
    @(negedge clk); cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R3 idle follows cpol", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R3 idle follows cpol", sclk, 0);

    // R10: slow divider, edge patterns 0x00 / 0xFF
    xfer(1'b0, 1'b0, 1'b0, 8'd7, 8'hFF, 8'h00, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 8'd5, 8'h00, 8'hFF, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule